// File: doc/BRIEF.md
# Write-Through L1 Data Cache with Acquire/Release Ordering

This block is a small direct-mapped first-level data cache for a GPU compute core. It accepts four kinds of core request (plain load, plain store, load-acquire, store-release) on a valid/ready port. Each load is answered with a one-cycle response pulse carrying the data. Each store is answered with a pulse once its write has been handed to the next level. The cache never asks for ownership of a line. Every store is forwarded at once to the next level as a write that carries only the bytes the store touched. A store that hits also updates the cached copy. A store that misses leaves the array alone.

Ordering between cores is achieved only through the two synchronising operations. A load-acquire drops every line in a single cycle and then reads from memory, so nothing stale can be returned afterwards. A store-release is held at the request port until the next level has acknowledged every earlier write-through. A counter of unacknowledged writes makes that wait possible, and the same counter also caps how many writes may be in flight. Plain loads and stores never wait on that counter, apart from that cap.

Top module: `wtl1_wt_cache`

## Requirements
- R1: After reset the request port is ready, no response is signalled and no memory request is presented.
- R2: A plain load (op code 2'b00) that misses issues exactly one memory read, with write low and an all-ones byte mask. It fills the line and returns the read data. A second load to the same word then hits, with no memory traffic.
- R3: A plain store (op code 2'b01) is presented on the memory port as a write in the state that follows acceptance. It carries the store's own byte mask, so memory bytes outside the mask keep their value. The core sees a response pulse once the write is handed off.
- R4: A store that hits merges its enabled bytes into the cached word, and a later load hit returns the merged word. A store that misses allocates nothing, so a later load to that word reads memory.
- R5: The array is direct-mapped. The low log2(LINES) bits of the word address select the line, and the remaining bits are the tag. A load to a different tag with the same index evicts the previous word.
- R6: A load-acquire (op code 2'b10) invalidates every line before its own read. It always reads memory, and words cached earlier miss afterwards. A plain load before any acquire still hits on stale data even when memory has changed.
- R7: In the cycle after a load-acquire is accepted, the whole-array invalidation takes place and the request port is not ready.
- R8: The count of unacknowledged writes rises on each write handshake and falls on each acknowledge. A store-release (op code 2'b11) is not accepted while this count is non-zero, so its write leaves only after all earlier writes have been acknowledged.
- R9: Plain stores and loads are accepted while earlier writes are still unacknowledged.
- R10: No store of either kind is accepted while PEND_MAX writes are unacknowledged.
- R11: While a memory request is presented and not accepted, it stays presented with its address, write flag, data and mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Core request accepted on this edge if valid |
| req_op | input | 2 | 00 load, 01 store, 10 load-acquire, 11 store-release |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Load data (zero for stores) |
| mem_req_valid | output | 1 | Next-level request present |
| mem_req_ready | input | 1 | Next level takes the request |
| mem_req_write | output | 1 | 1 for write-through, 0 for line read |
| mem_req_addr | output | ADDR_W | Word address of the request |
| mem_req_wdata | output | DATA_W | Write data |
| mem_req_be | output | DATA_W/8 | Bytes to update in memory |
| mem_fill_valid | input | 1 | Read data returned |
| mem_fill_data | input | DATA_W | Returned word |
| mem_wr_ack | input | 1 | One earlier write has completed |

## Verification
Several rules are checked on every cycle, whatever the traffic: a release is never accepted with writes pending, the outstanding count never exceeds its cap, each write handshake raises the count, an acquire leaves no valid line and stalls the port for one cycle, and a stalled memory request stays stable. Other rules can only be shown through the bench's scenarios, because they depend on data values in the bench's memory model. These include hit-versus-miss data, byte merging, non-allocation on store misses, index/tag eviction, stale hits being cured by an acquire, and the exact point at which a release or a capped store is let through.

// File: rtl/wtl1_pkg.sv
package wtl1_pkg;

   typedef enum logic [1:0] {
      OP_LOAD  = 2'b00,
      OP_STORE = 2'b01,
      OP_LDACQ = 2'b10,
      OP_STREL = 2'b11
   } wtl1_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FLUSH,
      ST_RDREQ,
      ST_RDWAIT,
      ST_WRREQ
   } wtl1_state_e;

endpackage

// File: rtl/wtl1_line_array.sv
module wtl1_line_array #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter int LINES  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        lk_addr,
   output logic                     lk_hit,
   output logic [DATA_W-1:0]        lk_data,
   input  logic                     flush_all,
   input  logic                     fill_en,
   input  logic [ADDR_W-1:0]        fill_addr,
   input  logic [DATA_W-1:0]        fill_data,
   input  logic                     merge_en,
   input  logic [DATA_W-1:0]        merge_data,
   input  logic [DATA_W/8-1:0]      merge_be,
   output logic [LINES-1:0]         valid_vec
);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;
   localparam int BYTES = DATA_W / 8;

   logic [IDX_W-1:0] lk_idx, fill_idx;
   logic [TAG_W-1:0] lk_tag, fill_tag;
   logic [TAG_W-1:0]  tag_arr  [LINES];
   logic [DATA_W-1:0] data_arr [LINES];

   assign lk_idx   = lk_addr[IDX_W-1:0];
   assign lk_tag   = lk_addr[ADDR_W-1:IDX_W];
   assign fill_idx = fill_addr[IDX_W-1:0];
   assign fill_tag = fill_addr[ADDR_W-1:IDX_W];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic              v_q;
      logic [TAG_W-1:0]  t_q;
      logic [DATA_W-1:0] d_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            t_q <= '0;
            d_q <= '0;
         end else if (flush_all) begin
            v_q <= 1'b0;
         end else if (fill_en && fill_idx == IDX_W'(g)) begin
            v_q <= 1'b1;
            t_q <= fill_tag;
            d_q <= fill_data;
         end else if (merge_en && lk_idx == IDX_W'(g)) begin
            for (int b = 0; b < BYTES; b++) begin
               if (merge_be[b]) d_q[b*8 +: 8] <= merge_data[b*8 +: 8];
            end
         end
      end

      assign valid_vec[g] = v_q;
      assign tag_arr[g]   = t_q;
      assign data_arr[g]  = d_q;
   end

   assign lk_hit  = valid_vec[lk_idx] && (tag_arr[lk_idx] == lk_tag);
   assign lk_data = data_arr[lk_idx];

endmodule

// File: rtl/wtl1_pend_ctr.sv
module wtl1_pend_ctr #(
   parameter int PEND_MAX = 4,
   localparam int CNT_W   = $clog2(PEND_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt,
   output logic             zero,
   output logic             full
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         unique case ({inc, dec})
            2'b10:   cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign cnt  = cnt_q;
   assign zero = (cnt_q == '0);
   assign full = (cnt_q == CNT_W'(PEND_MAX));

endmodule

// File: rtl/wtl1_wt_cache.sv
module wtl1_wt_cache
   import wtl1_pkg::*;
#(
   parameter int ADDR_W   = 10,
   parameter int DATA_W   = 32,
   parameter int LINES    = 8,
   parameter int PEND_MAX = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [1:0]          req_op,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [DATA_W/8-1:0] req_be,
   output logic                resp_valid,
   output logic [DATA_W-1:0]   resp_rdata,
   output logic                mem_req_valid,
   input  logic                mem_req_ready,
   output logic                mem_req_write,
   output logic [ADDR_W-1:0]   mem_req_addr,
   output logic [DATA_W-1:0]   mem_req_wdata,
   output logic [DATA_W/8-1:0] mem_req_be,
   input  logic                mem_fill_valid,
   input  logic [DATA_W-1:0]   mem_fill_data,
   input  logic                mem_wr_ack
);
   localparam int BYTES = DATA_W / 8;
   localparam int IDX_W = $clog2(LINES);
   localparam int CNT_W = $clog2(PEND_MAX + 1);

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data_w
      $error("DATA_W must be a whole number of bytes");
   end
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two, at least 2");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr_w
      $error("ADDR_W must leave at least one tag bit");
   end
   if (PEND_MAX < 1) begin : g_bad_pend
      $error("PEND_MAX must be at least 1");
   end

   wtl1_state_e         st_q, st_d;
   logic [ADDR_W-1:0]   r_addr;
   logic [DATA_W-1:0]   r_wdata;
   logic [BYTES-1:0]    r_be;
   logic                resp_v_q, resp_v_d;
   logic [DATA_W-1:0]   resp_q, resp_d;

   logic                accept, is_write_op;
   logic                lk_hit;
   logic [DATA_W-1:0]   lk_data;
   logic [LINES-1:0]    valid_vec;
   logic [CNT_W-1:0]    pend_cnt;
   logic                pend_zero, pend_full;
   logic                wr_hs;

   assign is_write_op = req_op[0];
   assign req_ready   = (st_q == ST_IDLE)
                        && !(is_write_op && pend_full)
                        && !(req_op == OP_STREL && !pend_zero);
   assign accept      = req_valid && req_ready;

   wtl1_line_array #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LINES  (LINES)
   ) i_lines (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_addr    (req_addr),
      .lk_hit     (lk_hit),
      .lk_data    (lk_data),
      .flush_all  (accept && req_op == OP_LDACQ),
      .fill_en    (st_q == ST_RDWAIT && mem_fill_valid),
      .fill_addr  (r_addr),
      .fill_data  (mem_fill_data),
      .merge_en   (accept && is_write_op && lk_hit),
      .merge_data (req_wdata),
      .merge_be   (req_be),
      .valid_vec  (valid_vec)
   );

   assign wr_hs = mem_req_valid && mem_req_ready && mem_req_write;

   wtl1_pend_ctr #(
      .PEND_MAX (PEND_MAX)
   ) i_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (wr_hs),
      .dec   (mem_wr_ack),
      .cnt   (pend_cnt),
      .zero  (pend_zero),
      .full  (pend_full)
   );

   always_comb begin
      st_d     = st_q;
      resp_v_d = 1'b0;
      resp_d   = resp_q;
      unique case (st_q)
         ST_IDLE: begin
            if (accept) begin
               if (req_op == OP_LOAD) begin
                  if (lk_hit) begin
                     resp_v_d = 1'b1;
                     resp_d   = lk_data;
                  end else begin
                     st_d = ST_RDREQ;
                  end
               end else if (req_op == OP_LDACQ) begin
                  st_d = ST_FLUSH;
               end else begin
                  st_d = ST_WRREQ;
               end
            end
         end
         ST_FLUSH: st_d = ST_RDREQ;
         ST_RDREQ: if (mem_req_ready) st_d = ST_RDWAIT;
         ST_RDWAIT: begin
            if (mem_fill_valid) begin
               st_d     = ST_IDLE;
               resp_v_d = 1'b1;
               resp_d   = mem_fill_data;
            end
         end
         ST_WRREQ: begin
            if (mem_req_ready) begin
               st_d     = ST_IDLE;
               resp_v_d = 1'b1;
               resp_d   = '0;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         r_addr   <= '0;
         r_wdata  <= '0;
         r_be     <= '0;
         resp_v_q <= 1'b0;
         resp_q   <= '0;
      end else begin
         st_q     <= st_d;
         resp_v_q <= resp_v_d;
         resp_q   <= resp_d;
         if (accept) begin
            r_addr  <= req_addr;
            r_wdata <= req_wdata;
            r_be    <= req_be;
         end
      end
   end

   assign resp_valid    = resp_v_q;
   assign resp_rdata    = resp_q;
   assign mem_req_valid = (st_q == ST_RDREQ) || (st_q == ST_WRREQ);
   assign mem_req_write = (st_q == ST_WRREQ);
   assign mem_req_addr  = r_addr;
   assign mem_req_wdata = r_wdata;
   assign mem_req_be    = (st_q == ST_WRREQ) ? r_be : '1;

endmodule

// File: rtl/wtl1_wt_cache_chk.sv
module wtl1_wt_cache_chk #(
   parameter int ADDR_W   = 10,
   parameter int DATA_W   = 32,
   parameter int LINES    = 8,
   parameter int PEND_MAX = 4,
   localparam int CNT_W   = $clog2(PEND_MAX + 1)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_ready,
   input logic [1:0]          req_op,
   input logic                mem_req_valid,
   input logic                mem_req_ready,
   input logic                mem_req_write,
   input logic [ADDR_W-1:0]   mem_req_addr,
   input logic [DATA_W-1:0]   mem_req_wdata,
   input logic [DATA_W/8-1:0] mem_req_be,
   input logic                mem_wr_ack,
   input logic [CNT_W-1:0]    pend_cnt,
   input logic [LINES-1:0]    valid_vec
);

   // R11
   mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr)
          && $stable(mem_req_wdata) && $stable(mem_req_be)));

   // R8
   release_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_op == 2'b11) |-> (pend_cnt == '0));

   // R8
   pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready && mem_req_write && !mem_wr_ack) |=>
         (pend_cnt == $past(pend_cnt) + CNT_W'(1)));

   // R8
   ack_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_ack |-> (pend_cnt != '0));

   // R10
   pend_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_cnt <= CNT_W'(PEND_MAX));

   // R6
   acq_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_op == 2'b10) |=> (valid_vec == '0));

   // R7
   acq_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_op == 2'b10) |=> !req_ready);

endmodule

bind wtl1_wt_cache wtl1_wt_cache_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .LINES    (LINES),
   .PEND_MAX (PEND_MAX)
) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_op        (req_op),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_write (mem_req_write),
   .mem_req_addr  (mem_req_addr),
   .mem_req_wdata (mem_req_wdata),
   .mem_req_be    (mem_req_be),
   .mem_wr_ack    (mem_wr_ack),
   .pend_cnt      (pend_cnt),
   .valid_vec     (valid_vec)
);

// File: tb/test_wtl1_wt_cache.sv
module test_wtl1_wt_cache;
   localparam int AW = 10;
   localparam int DW = 32;
   localparam int BW = DW / 8;
   localparam int PMAX = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_op = 2'b00;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [BW-1:0] req_be = '0;
   logic          resp_valid;
   logic [DW-1:0] resp_rdata;
   logic          mem_req_valid;
   logic          mem_req_ready = 1'b0;
   logic          mem_req_write;
   logic [AW-1:0] mem_req_addr;
   logic [DW-1:0] mem_req_wdata;
   logic [BW-1:0] mem_req_be;
   logic          mem_fill_valid = 1'b0;
   logic [DW-1:0] mem_fill_data = '0;
   logic          mem_wr_ack = 1'b0;

   always #2 clk = ~clk;

   wtl1_wt_cache #(
      .ADDR_W   (AW),
      .DATA_W   (DW),
      .LINES    (8),
      .PEND_MAX (PMAX)
   ) i_wtl1_wt_cache (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_ready      (req_ready),
      .req_op         (req_op),
      .req_addr       (req_addr),
      .req_wdata      (req_wdata),
      .req_be         (req_be),
      .resp_valid     (resp_valid),
      .resp_rdata     (resp_rdata),
      .mem_req_valid  (mem_req_valid),
      .mem_req_ready  (mem_req_ready),
      .mem_req_write  (mem_req_write),
      .mem_req_addr   (mem_req_addr),
      .mem_req_wdata  (mem_req_wdata),
      .mem_req_be     (mem_req_be),
      .mem_fill_valid (mem_fill_valid),
      .mem_fill_data  (mem_fill_data),
      .mem_wr_ack     (mem_wr_ack)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory model
   logic [DW-1:0] mem [1024];
   int  cyc = 0;
   int  nreads = 0;
   int  nwrites = 0;
   int  out_wr = 0;
   int  wr_pre [64];
   int  ackq [16];
   int  ackn = 0;
   int  ack_lat = 3;
   bit  stall_mode = 1'b0;
   bit  fill_pend = 1'b0;
   int  fill_due = 0;
   logic [DW-1:0] fill_buf = '0;

   always @(negedge clk) begin
      cyc++;
      mem_req_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
      mem_fill_valid = 1'b0;
      if (fill_pend && cyc >= fill_due) begin
         mem_fill_valid = 1'b1;
         mem_fill_data  = fill_buf;
         fill_pend      = 1'b0;
      end
      mem_wr_ack = 1'b0;
      if (ackn > 0 && cyc >= ackq[0]) begin
         mem_wr_ack = 1'b1;
         for (int i = 0; i < 15; i++) ackq[i] = ackq[i+1];
         ackn--;
         out_wr--;
      end
      if (rst_n && mem_req_valid && mem_req_ready) begin
         if (mem_req_write) begin
            wr_pre[nwrites % 64] = out_wr;
            nwrites++;
            out_wr++;
            for (int b = 0; b < BW; b++)
               if (mem_req_be[b]) mem[mem_req_addr][b*8 +: 8] = mem_req_wdata[b*8 +: 8];
            ackq[ackn] = cyc + ack_lat;
            ackn++;
         end else begin
            nreads++;
            fill_pend = 1'b1;
            fill_due  = cyc + 2;
            fill_buf  = mem[mem_req_addr];
         end
      end
   end

   task automatic do_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic [BW-1:0] be, output logic [DW-1:0] rd, output int nrd,
                        output logic rdy_after, output int waitc);
      int r0;
      r0 = nreads;
      waitc = 0;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd; req_be = be;
      #0;
      while (!req_ready) begin
         @(negedge clk);
         waitc++;
      end
      @(negedge clk);
      req_valid = 1'b0;
      rdy_after = req_ready;
      while (!resp_valid) @(negedge clk);
      rd  = resp_rdata;
      nrd = nreads - r0;
   endtask

   typedef struct packed {
      logic [1:0]  op;
      logic [9:0]  addr;
      logic [31:0] wd;
      logic [3:0]  be;
      logic [31:0] exp;
      logic        rd;
   } vec_t;

   localparam vec_t TBL [8] = '{
      '{2'b00, 10'h010, 32'h0,        4'h0, 32'hC0DE0010, 1'b1},
      '{2'b00, 10'h010, 32'h0,        4'h0, 32'hC0DE0010, 1'b0},
      '{2'b01, 10'h010, 32'h11223344, 4'h1, 32'h0,        1'b0},
      '{2'b00, 10'h010, 32'h0,        4'h0, 32'hC0DE0044, 1'b0},
      '{2'b01, 10'h023, 32'hAABBCCDD, 4'hC, 32'h0,        1'b0},
      '{2'b00, 10'h023, 32'h0,        4'h0, 32'hAABB0023, 1'b1},
      '{2'b00, 10'h018, 32'h0,        4'h0, 32'hC0DE0018, 1'b1},
      '{2'b00, 10'h010, 32'h0,        4'h0, 32'hC0DE0044, 1'b1}
   };

   function automatic string row_req(int i);
      case (i)
         0, 1:    return "R2";
         2, 4:    return "R3";
         3, 5:    return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic drain();
      while (out_wr != 0) @(negedge clk);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      logic [DW-1:0] rd;
      int nrd, waitc, w0;
      logic ra;
      for (int i = 0; i < 1024; i++) mem[i] = 32'hC0DE0000 | i;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 ready", {31'd0, req_ready}, 32'd1);
      chk("R1 resp_valid", {31'd0, resp_valid}, 32'd0);
      chk("R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);

      for (int i = 0; i < 8; i++) begin
         do_op(TBL[i].op, TBL[i].addr, TBL[i].wd, TBL[i].be, rd, nrd, ra, waitc);
         chk({row_req(i), " data"}, rd, TBL[i].exp);
         chk({row_req(i), " reads"}, nrd, {31'd0, TBL[i].rd});
      end
      // R3: masked bytes only
      chk("R3 mem 0x010", mem[10'h010], 32'hC0DE0044);
      chk("R3 mem 0x023", mem[10'h023], 32'hAABB0023);

      // R6: stale hit, acquire refreshes
      mem[10'h010] = 32'h55555555;
      do_op(2'b00, 10'h010, '0, '0, rd, nrd, ra, waitc);
      chk("R6 stale hit data", rd, 32'hC0DE0044);
      chk("R6 stale hit reads", nrd, 0);
      do_op(2'b10, 10'h018, '0, '0, rd, nrd, ra, waitc);
      chk("R7 port stalled after acquire", {31'd0, ra}, 32'd0);
      chk("R6 acquire data", rd, 32'hC0DE0018);
      chk("R6 acquire reads", nrd, 1);
      do_op(2'b00, 10'h010, '0, '0, rd, nrd, ra, waitc);
      chk("R6 post-acquire data", rd, 32'h55555555);
      chk("R6 post-acquire reads", nrd, 1);
      do_op(2'b00, 10'h023, '0, '0, rd, nrd, ra, waitc);
      chk("R6 other line invalidated", nrd, 1);

      // R9: plain ops do not wait for acks
      drain();
      ack_lat = 40;
      w0 = nwrites;
      do_op(2'b01, 10'h100, 32'h1, 4'hF, rd, nrd, ra, waitc);
      do_op(2'b01, 10'h101, 32'h2, 4'hF, rd, nrd, ra, waitc);
      chk("R9 second store overlaps", wr_pre[(w0 + 1) % 64], 1);
      do_op(2'b00, 10'h010, '0, '0, rd, nrd, ra, waitc);
      chk("R9 load hit with writes pending", {31'd0, out_wr > 0}, 32'd1);

      // R8: release waits for all acks
      w0 = nwrites;
      do_op(2'b11, 10'h102, 32'h3, 4'hF, rd, nrd, ra, waitc);
      chk("R8 release sent with none pending", wr_pre[w0 % 64], 0);
      chk("R8 release was held", {31'd0, waitc > 0}, 32'd1);
      chk("R8 release data", mem[10'h102], 32'h3);

      // R10: cap on outstanding writes
      drain();
      w0 = nwrites;
      do_op(2'b01, 10'h110, 32'h4, 4'hF, rd, nrd, ra, waitc);
      do_op(2'b01, 10'h111, 32'h5, 4'hF, rd, nrd, ra, waitc);
      do_op(2'b01, 10'h112, 32'h6, 4'hF, rd, nrd, ra, waitc);
      chk("R10 third store held", {31'd0, waitc > 0}, 32'd1);
      chk("R10 third store count", wr_pre[(w0 + 2) % 64], 1);

      // R11: stalled memory port
      drain();
      ack_lat = 3;
      stall_mode = 1'b1;
      do_op(2'b01, 10'h120, 32'h99887766, 4'h6, rd, nrd, ra, waitc);
      chk("R11 store under stall", mem[10'h120], 32'hC0887720);
      do_op(2'b00, 10'h121, '0, '0, rd, nrd, ra, waitc);
      chk("R11 load under stall", rd, 32'hC0DE0121);
      stall_mode = 1'b0;
      drain();

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=complete");
         summary();
         $finish;
      end
   end

endmodule